// File: doc/BRIEF.md
# Linked-List Burst Read Requester

This block walks linked chains of memory rows on behalf of a receive path. It takes 32-bit chain descriptors from an upstream FIFO. Each descriptor gives a row address and a chain length. For each descriptor it issues AXI4 read-address requests that cover the whole chain. Every request is an incrementing burst of 256-bit beats. The chain is cut into full 16-beat bursts, and a shorter burst closes it when the length is not a multiple of sixteen. The block drives only the read-address channel and the FIFO read enable. Read data, writes and descriptor generation belong to neighbouring logic.

A run begins with a start pulse. The block then pops descriptors one at a time and finishes each chain before it pops the next. A run carries no end-of-list marker. Instead, the run is closed once the FIFO has stayed empty for a fixed idle window, counted only after the earlier receive phase has reported completion. A sticky done flag then tells the sequencer that all requests have gone out. A running beat total lets the receive side confirm that it has collected every beat.

Top module: `chain_burst_reader`

## Requirements
- R1: A descriptor carries the chain length minus one in bits [31:23] (9 bits) and the starting row address, in 32-byte units, in bits [22:0].
- R2: Every request carries the byte address {5'b0, row, 5'b00000} on a 33-bit bus, with ar_size = 3'd5, ar_burst = 2'b01 (incrementing) and ar_id = 0.
- R3: A chain of L+1 beats is requested as full bursts with ar_len = 15 while more than 16 beats remain, then one burst of the remaining beats (ar_len = remaining - 1). A length field of 35 gives bursts of 16, 16 and 4 beats.
- R4: Each accepted request advances the row address by the number of beats it carried, so the bursts of one chain cover consecutive rows.
- R5: Once ar_valid is raised it stays high, with ar_addr and ar_len unchanged, until ar_ready is seen.
- R6: fifo_rd is a one-cycle pulse, raised only while the block waits for a descriptor and the FIFO is not empty. It is never raised while a request is pending, before a run starts, or after the run has ended.
- R7: After the last burst of a chain is accepted, the block drops ar_valid and takes the next descriptor.
- R8: The run ends (send_done rises) after 256 consecutive clock edges during which the block waits for a descriptor, the earlier phase reports done, and the FIFO is empty. Any new descriptor restarts that window.
- R9: While prev_rx_done is low, an empty FIFO never ends the run.
- R10: send_done stays high until the next run_start. run_start begins a new run, clears send_done and clears the beat total.
- R11: beats_issued equals the sum of the beats of all accepted requests since the last run_start.
- R12: During and right after reset, ar_valid, fifo_rd and send_done are low and beats_issued is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_start | input | 1 | Begins a new run when idle or done |
| prev_rx_done | input | 1 | Earlier receive phase has finished |
| fifo_empty | input | 1 | Descriptor FIFO empty flag |
| fifo_data | input | 32 | Descriptor at the FIFO head |
| fifo_rd | output | 1 | Descriptor FIFO read enable |
| ar_addr | output | 33 | Read byte address |
| ar_len | output | 8 | Burst length minus one |
| ar_size | output | 3 | Beat size code (32 bytes) |
| ar_burst | output | 2 | Burst type (incrementing) |
| ar_id | output | 6 | Transaction ID (zero) |
| ar_valid | output | 1 | Read request valid |
| ar_ready | input | 1 | Read request accepted |
| send_done | output | 1 | All requests of the run issued |
| beats_issued | output | 32 | Beats requested since run start |

## Verification
The splitter is driven with chain lengths that each probe a different edge of the cut: one beat, exactly sixteen, seventeen, thirty-six, an exact multiple of sixteen, and the 512-beat maximum. Off-by-one faults in the final burst or in the full-burst test show up on at least one of these. Random ar_ready stalls separate a request that holds steady from one that drifts or double-issues. The idle window is measured to the exact edge, with gating from prev_rx_done and an interrupting descriptor, so that a wrong limit, a missing gate or a counter that never clears each show up.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_POP  = 2'd1,
      ST_SEND = 2'd2,
      ST_DONE = 2'd3
   } cbr_state_e;

   localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/cbr_burst_calc.sv
module cbr_burst_calc #(
   parameter int LEN_W = 9,
   parameter int SEG_W = 4
) (
   input  logic [LEN_W-1:0] chain_len,
   input  logic [LEN_W-1:0] chain_ctr,
   output logic [SEG_W-1:0] seg_len,
   output logic             last_seg
);

   if (SEG_W < 1) begin : g_bad_seg
      $error("cbr_burst_calc: SEG_W must be at least 1");
   end

   if (LEN_W > SEG_W) begin : g_split
      logic same_block;
      assign same_block = (chain_ctr[LEN_W-1:SEG_W] == chain_len[LEN_W-1:SEG_W]);
      assign last_seg   = same_block;
      assign seg_len    = same_block ? chain_len[SEG_W-1:0] : {SEG_W{1'b1}};
   end else begin : g_single
      logic unused_ctr;
      assign unused_ctr = ^chain_ctr;
      assign last_seg   = 1'b1;
      assign seg_len    = SEG_W'(chain_len);
   end

endmodule

// File: rtl/cbr_idle_timer.sv
module cbr_idle_timer #(
   parameter int LIMIT = 255
) (
   input  logic clk,
   input  logic rst_n,
   input  logic count_en,
   output logic expired
);

   localparam int CNT_W = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("cbr_idle_timer: LIMIT must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   assign expired = (cnt_q == CNT_W'(LIMIT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!count_en) begin
         cnt_q <= '0;
      end else if (!expired) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assert_window_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(LIMIT));

   assert_window_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !count_en |=> !expired);

endmodule

// File: rtl/cbr_addr_fmt.sv
module cbr_addr_fmt #(
   parameter int ROW_W   = 23,
   parameter int SHIFT   = 5,
   parameter int ADDR_W  = 33
) (
   input  logic [ROW_W-1:0]  row,
   output logic [ADDR_W-1:0] byte_addr
);

   localparam int USED_W = ROW_W + SHIFT;

   if (ADDR_W < USED_W) begin : g_bad_width
      $error("cbr_addr_fmt: ADDR_W too narrow for row and offset");
   end

   if (ADDR_W > USED_W) begin : g_padded
      assign byte_addr = {{(ADDR_W - USED_W){1'b0}}, row, {SHIFT{1'b0}}};
   end else begin : g_exact
      assign byte_addr = {row, {SHIFT{1'b0}}};
   end

endmodule

// File: rtl/chain_burst_reader.sv
module chain_burst_reader #(
   parameter int DESC_W     = 32,
   parameter int LEN_W      = 9,
   parameter int ROW_W      = 23,
   parameter int ADDR_W     = 33,
   parameter int BYTE_SHIFT = 5,
   parameter int MAX_BURST  = 16,
   parameter int IDLE_LIMIT = 255,
   parameter int ID_W       = 6,
   parameter int BEAT_CNT_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run_start,
   input  logic                  prev_rx_done,
   input  logic                  fifo_empty,
   input  logic [DESC_W-1:0]     fifo_data,
   output logic                  fifo_rd,
   output logic [ADDR_W-1:0]     ar_addr,
   output logic [7:0]            ar_len,
   output logic [2:0]            ar_size,
   output logic [1:0]            ar_burst,
   output logic [ID_W-1:0]       ar_id,
   output logic                  ar_valid,
   input  logic                  ar_ready,
   output logic                  send_done,
   output logic [BEAT_CNT_W-1:0] beats_issued
);

   import cbr_pkg::*;

   localparam int SEG_W     = $clog2(MAX_BURST);
   localparam int STEP_W    = SEG_W + 1;
   localparam int LEN_LSB   = ROW_W;
   localparam int SIZE_CODE = BYTE_SHIFT;

   if (DESC_W < LEN_W + ROW_W) begin : g_bad_desc
      $error("chain_burst_reader: descriptor too narrow for length and row");
   end
   if ((1 << SEG_W) != MAX_BURST || SEG_W > 8 || SEG_W < 1) begin : g_bad_burst
      $error("chain_burst_reader: MAX_BURST must be a power of two from 2 to 256");
   end
   if (SIZE_CODE > 7) begin : g_bad_size
      $error("chain_burst_reader: BYTE_SHIFT exceeds the beat size code range");
   end

   cbr_state_e            state_q, state_d;
   logic [LEN_W-1:0]      len_q;
   logic [LEN_W-1:0]      ctr_q;
   logic [ROW_W-1:0]      row_q;
   logic [BEAT_CNT_W-1:0] beats_q;

   logic [SEG_W-1:0]      seg_len;
   logic                  last_seg;
   logic [STEP_W-1:0]     step;
   logic                  handshake;
   logic                  idle_count_en;
   logic                  idle_expired;
   logic                  start_ok;

   cbr_burst_calc #(
      .LEN_W (LEN_W),
      .SEG_W (SEG_W)
   ) u_burst_calc (
      .chain_len (len_q),
      .chain_ctr (ctr_q),
      .seg_len   (seg_len),
      .last_seg  (last_seg)
   );

   cbr_idle_timer #(
      .LIMIT (IDLE_LIMIT)
   ) u_idle_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (idle_count_en),
      .expired  (idle_expired)
   );

   cbr_addr_fmt #(
      .ROW_W  (ROW_W),
      .SHIFT  (BYTE_SHIFT),
      .ADDR_W (ADDR_W)
   ) u_addr_fmt (
      .row       (row_q),
      .byte_addr (ar_addr)
   );

   if (DESC_W > LEN_W + ROW_W) begin : g_desc_spare
      logic unused_desc;
      assign unused_desc = ^fifo_data[DESC_W-1:LEN_W+ROW_W];
   end

   assign ar_valid      = (state_q == ST_SEND);
   assign fifo_rd       = (state_q == ST_POP) && !fifo_empty;
   assign send_done     = (state_q == ST_DONE);
   assign ar_len        = 8'(seg_len);
   assign ar_size       = 3'(SIZE_CODE);
   assign ar_burst      = BURST_INCR;
   assign ar_id         = '0;
   assign beats_issued  = beats_q;

   assign step          = STEP_W'(seg_len) + 1'b1;
   assign handshake     = ar_valid && ar_ready;
   assign idle_count_en = (state_q == ST_POP) && prev_rx_done && fifo_empty;
   assign start_ok      = run_start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (run_start) state_d = ST_POP;
         ST_POP: begin
            if (!fifo_empty)                        state_d = ST_SEND;
            else if (idle_count_en && idle_expired) state_d = ST_DONE;
         end
         ST_SEND: if (handshake && last_seg) state_d = ST_POP;
         ST_DONE: if (run_start) state_d = ST_POP;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         len_q   <= '0;
         ctr_q   <= '0;
         row_q   <= '0;
         beats_q <= '0;
      end else begin
         state_q <= state_d;
         if (fifo_rd) begin
            len_q <= fifo_data[LEN_LSB +: LEN_W];
            row_q <= fifo_data[ROW_W-1:0];
            ctr_q <= '0;
         end else if (handshake) begin
            row_q <= row_q + ROW_W'(step);
            ctr_q <= ctr_q + LEN_W'(step);
         end
         if (start_ok) begin
            beats_q <= '0;
         end else if (handshake) begin
            beats_q <= beats_q + BEAT_CNT_W'(step);
         end
      end
   end

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_len));

   assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |=> !fifo_rd);

   assert_rd_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> !fifo_empty);

   assert_rd_not_during_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_rd && ar_valid));

   assert_burst_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ar_valid |-> ar_len < 8'(MAX_BURST));

   assert_chain_continues_R7: assert property (@(posedge clk) disable iff (!rst_n)
      handshake && !last_seg |=> ar_valid);

   assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      send_done && !run_start |=> send_done);

   assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      send_done && run_start |=> !send_done && beats_issued == '0);

endmodule

// File: tb/chain_burst_reader_tb.sv
module chain_burst_reader_tb;

   logic        clk;
   logic        rst_n;
   logic        run_start;
   logic        prev_rx_done;
   logic        fifo_empty;
   logic [31:0] fifo_data;
   logic        fifo_rd;
   logic [32:0] ar_addr;
   logic [7:0]  ar_len;
   logic [2:0]  ar_size;
   logic [1:0]  ar_burst;
   logic [5:0]  ar_id;
   logic        ar_valid;
   logic        ar_ready;
   logic        send_done;
   logic [31:0] beats_issued;

   int n_checks = 0;
   int n_fail   = 0;

   // {stall[1:0], len_minus_one[8:0], row[22:0]}
   localparam int NVEC = 7;
   localparam logic [33:0] VEC [NVEC] = '{
      {2'd2, 9'd35,  23'h000100},
      {2'd0, 9'd0,   23'h001234},
      {2'd1, 9'd15,  23'h000020},
      {2'd3, 9'd16,  23'h000400},
      {2'd0, 9'd47,  23'h020000},
      {2'd1, 9'd511, 23'h010000},
      {2'd0, 9'd1,   23'h7FFF00}
   };

   chain_burst_reader u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_start    (run_start),
      .prev_rx_done (prev_rx_done),
      .fifo_empty   (fifo_empty),
      .fifo_data    (fifo_data),
      .fifo_rd      (fifo_rd),
      .ar_addr      (ar_addr),
      .ar_len       (ar_len),
      .ar_size      (ar_size),
      .ar_burst     (ar_burst),
      .ar_id        (ar_id),
      .ar_valid     (ar_valid),
      .ar_ready     (ar_ready),
      .send_done    (send_done),
      .beats_issued (beats_issued)
   );

   initial begin
      clk = 1'b0;
      forever #4 clk = ~clk;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   // Feeds one descriptor and follows every burst of its chain (R1..R5, R7).
   task automatic run_desc(input logic [33:0] v);
      logic [8:0]  len;
      logic [22:0] crow;
      int          stall;
      int          sent;
      int          rem;
      int          exp_len;
      logic [32:0] exp_addr;
      len   = v[31:23];
      crow  = v[22:0];
      stall = int'(v[33:32]);
      fifo_data  = v[31:0];
      fifo_empty = 1'b0;
      #1;
      check(fifo_rd === 1'b1, "R6 pop pulse", 64'(fifo_rd), 64'd1);
      check(ar_valid === 1'b0, "R7 idle between chains", 64'(ar_valid), 64'd0);
      @(negedge clk);
      fifo_empty = 1'b1;
      fifo_data  = 32'h0;
      #1;
      check(fifo_rd === 1'b0, "R6 pulse width", 64'(fifo_rd), 64'd0);
      sent = 0;
      while (sent < int'(len) + 1) begin
         rem      = int'(len) + 1 - sent;
         exp_len  = (rem > 16) ? 15 : rem - 1;
         exp_addr = {5'b0, crow, 5'b0};
         check(ar_valid === 1'b1, "R3 request raised", 64'(ar_valid), 64'd1);
         check(ar_addr === exp_addr, "R1 R4 burst address", 64'(ar_addr), 64'(exp_addr));
         check(ar_len === 8'(exp_len), "R3 burst length", 64'(ar_len), 64'(exp_len));
         if (sent == 0) begin
            check(ar_size === 3'd5 && ar_burst === 2'b01 && ar_id === 6'd0,
                  "R2 fixed attributes", {ar_size, ar_burst, ar_id}, {3'd5, 2'b01, 6'd0});
         end
         for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            #1;
            check(ar_valid === 1'b1 && ar_addr === exp_addr && ar_len === 8'(exp_len),
                  "R5 held request", 64'(ar_addr), 64'(exp_addr));
            check(fifo_rd === 1'b0, "R6 no pop while pending", 64'(fifo_rd), 64'd0);
         end
         ar_ready = 1'b1;
         @(negedge clk);
         ar_ready = 1'b0;
         #1;
         sent += exp_len + 1;
         crow += 23'(exp_len + 1);
      end
      check(ar_valid === 1'b0, "R7 chain closed", 64'(ar_valid), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R8 actual=hung expected=finish");
      report();
      $finish;
   end

   initial begin
      int total;
      int n;
      rst_n        = 1'b0;
      run_start    = 1'b0;
      prev_rx_done = 1'b0;
      fifo_empty   = 1'b0;
      fifo_data    = 32'hFFFF_FFFF;
      ar_ready     = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(ar_valid === 1'b0 && fifo_rd === 1'b0, "R12 reset outputs",
            {ar_valid, fifo_rd}, 64'd0);
      check(send_done === 1'b0 && beats_issued === 32'd0, "R12 reset state",
            64'(beats_issued), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(fifo_rd === 1'b0, "R6 no pop before run", 64'(fifo_rd), 64'd0);
      fifo_empty = 1'b1;
      run_start  = 1'b1;
      @(negedge clk);
      run_start    = 1'b0;
      prev_rx_done = 1'b1;
      total = 0;

      for (int i = 0; i < NVEC; i++) begin
         run_desc(VEC[i]);
         total += int'(VEC[i][31:23]) + 1;
         if (i == 1) begin
            repeat (200) @(negedge clk);
            #1;
            check(send_done === 1'b0, "R8 window not yet elapsed", 64'(send_done), 64'd0);
         end
      end
      check(beats_issued === 32'(total), "R11 beat total", 64'(beats_issued), 64'(total));

      prev_rx_done = 1'b0;
      repeat (400) @(negedge clk);
      #1;
      check(send_done === 1'b0, "R9 gated by earlier phase", 64'(send_done), 64'd0);

      prev_rx_done = 1'b1;
      n = 0;
      while (!send_done && n < 1000) begin
         @(negedge clk);
         #1;
         n++;
      end
      check(n == 256, "R8 idle window length", 64'(n), 64'd256);

      fifo_empty = 1'b0;
      fifo_data  = {9'd3, 23'h000777};
      repeat (20) begin
         @(negedge clk);
         #1;
         check(fifo_rd === 1'b0 && send_done === 1'b1, "R10 R6 done holds",
               {fifo_rd, send_done}, 64'b01);
      end
      fifo_empty = 1'b1;
      run_start  = 1'b1;
      @(negedge clk);
      run_start = 1'b0;
      #1;
      check(send_done === 1'b0 && beats_issued === 32'd0, "R10 restart clears",
            {send_done, beats_issued}, 64'd0);
      run_desc({2'd1, 9'd3, 23'h000777});
      check(beats_issued === 32'd4, "R11 count after restart", 64'(beats_issued), 64'd4);

      report();
      $finish;
   end

endmodule